// File: doc/BRIEF.md
# Selectable-Source Shared Time Base

This block is a free-running 16-bit up-counter. A group of compare and capture channels can use its value as a common time reference. The counter advances by one on each pulse from the source selected in its mode register. There are four sources: the system clock divided by 12, the system clock divided by 4, an overflow pulse from another timer, and an external clock pin. The external pin is synchronized first, and the counter takes one step for each rising edge it sees.

Software controls the block through a small byte-wide register port. Counting happens only while the run bit is set. A mode bit can also freeze counting while the processor reports that it is idle. When the counter wraps from all ones to zero it sets a sticky overflow flag. If the overflow interrupt is enabled, that flag drives the interrupt line. Software can read or write both count bytes at any time. A byte write wins over an increment that falls in the same cycle.

Top module: `shared_timebase`

## Requirements
- R1: After reset, count_o is 0, irq_o is 0, and the mode and control registers read back as 0.
- R2: Address 0 holds the count low byte and address 1 holds the count high byte. Address 2 is the mode register: bits 1:0 select the source, bit 2 is the idle-freeze enable and bit 3 is the overflow interrupt enable. Address 3 is the control register: bit 0 is run and bit 1 is the overflow flag. rd_data_o presents the register at addr_i one clock after addr_i is applied.
- R3: Source code 00 advances the count once every 12 clock cycles.
- R4: Source code 01 advances the count once every 4 clock cycles.
- R5: Source code 10 advances the count once for each clock cycle in which tmr_ovf_i is high.
- R6: Source code 11 advances the count once for each rising edge of ext_clk_i. The edge passes through a two-flop synchronizer, so the step is visible 3 clock edges after the pin rises.
- R7: While run is 0, the count does not change.
- R8: While idle-freeze is 1 and idle_i is high, the count does not change. When idle-freeze is 0, idle_i has no effect.
- R9: A wrap from 0xFFFF to 0x0000 sets the overflow flag. The flag stays set until software writes 0 to control bit 1. If a wrap and a clearing write fall in the same cycle, the flag stays set.
- R10: irq_o equals the overflow flag ANDed with the interrupt enable, one cycle later.
- R11: A write to a count byte takes priority over an increment in the same cycle. The written byte holds the written value and the other byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_i | input | 1 | Processor-idle indication |
| tmr_ovf_i | input | 1 | Overflow pulse from another timer |
| ext_clk_i | input | 1 | Asynchronous external count pin |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Registered read data |
| count_o | output | 16 | Current time-base value |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is a counter wrap that lands in the same cycle as a software write clearing the flag. The bench loads 0xFFFF while counting is paused. It then raises the timer-overflow input and issues the clearing control write on the same clock edge. This creates the collision deterministically instead of waiting for it to happen by chance. The bench also checks the exact latency of the synchronizer on the pin source and the precise rate of each prescaler over whole periods, which makes the result independent of the divider phase.

// File: rtl/stb_pkg.sv
package stb_pkg;
  typedef enum logic [1:0] {
    SRC_DIV_SLOW = 2'b00,
    SRC_DIV_FAST = 2'b01,
    SRC_TMR_OVF  = 2'b10,
    SRC_PIN      = 2'b11
  } src_sel_e;

  localparam int MODE_SRC_LSB   = 0;
  localparam int MODE_IDLE_BIT  = 2;
  localparam int MODE_IE_BIT    = 3;
  localparam int CTRL_RUN_BIT   = 0;
  localparam int CTRL_FLAG_BIT  = 1;
endpackage

// File: rtl/stb_prescaler.sv
module stb_prescaler #(
  parameter int RATIO = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int PW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      tick_o  <= 1'b0;
    end else begin
      tick_o  <= (phase_q == LAST);
      phase_q <= (phase_q == LAST) ? '0 : phase_q + PW'(1);
    end
  end
endmodule

// File: rtl/stb_edge_sync.sv
module stb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its delayed copy
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/stb_counter.sv
module stb_counter #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inc_i,
  input  logic [NBYTES-1:0]        byte_we_i,
  input  logic [BYTE_W-1:0]        wdata_i,
  output logic [BYTE_W*NBYTES-1:0] count_o,
  output logic                     wrap_o
);
  localparam int CW = BYTE_W * NBYTES;

  logic          any_we;
  logic          advance;
  logic [CW-1:0] count_q;
  logic [CW-1:0] count_inc;

  assign any_we    = |byte_we_i;
  assign advance   = inc_i & ~any_we;
  assign count_inc = count_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (any_we) begin
      for (int b = 0; b < NBYTES; b++)
        if (byte_we_i[b]) count_q[b*BYTE_W +: BYTE_W] <= wdata_i;
    end else if (advance) begin
      count_q <= count_inc;
    end
  end

  assign count_o = count_q;
  assign wrap_o  = advance & (&count_q);
endmodule

// File: rtl/shared_timebase.sv
module shared_timebase
  import stb_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int NBYTES      = 2,
  parameter int SLOW_DIV    = 12,
  parameter int FAST_DIV    = 4,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(NBYTES + 2)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     idle_i,
  input  logic                     tmr_ovf_i,
  input  logic                     ext_clk_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  output logic [BYTE_W-1:0]        rd_data_o,
  output logic [BYTE_W*NBYTES-1:0] count_o,
  output logic                     irq_o
);
  localparam int CW = BYTE_W * NBYTES;
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NBYTES);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NBYTES + 1);

  src_sel_e          src_q;
  logic              idle_stop_q;
  logic              ie_q;
  logic              run_q;
  logic              flag_q;
  logic [1:0]        div_ticks;
  logic              pin_rise;
  logic              src_tick;
  logic              count_en;
  logic              wrap;
  logic [NBYTES-1:0] byte_we;
  logic [BYTE_W-1:0] rd_next;

  // Two free-running clock prescalers; index 0 is the slow ratio
  for (genvar g = 0; g < 2; g++) begin : gen_div
    stb_prescaler #(.RATIO(g == 0 ? SLOW_DIV : FAST_DIV)) u_div (
      .clk    (clk),
      .rst    (rst),
      .tick_o (div_ticks[g])
    );
  end

  stb_edge_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk     (clk),
    .rst     (rst),
    .async_i (ext_clk_i),
    .rise_o  (pin_rise)
  );

  always_comb begin
    unique case (src_q)
      SRC_DIV_SLOW: src_tick = div_ticks[0];
      SRC_DIV_FAST: src_tick = div_ticks[1];
      SRC_TMR_OVF:  src_tick = tmr_ovf_i;
      default:      src_tick = pin_rise;
    endcase
  end

  assign count_en = run_q & ~(idle_stop_q & idle_i) & src_tick;

  for (genvar b = 0; b < NBYTES; b++) begin : gen_we
    assign byte_we[b] = wr_en_i && (addr_i == ADDR_W'(b));
  end

  stb_counter #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .inc_i     (count_en),
    .byte_we_i (byte_we),
    .wdata_i   (wr_data_i),
    .count_o   (count_o),
    .wrap_o    (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q       <= SRC_DIV_SLOW;
      idle_stop_q <= 1'b0;
      ie_q        <= 1'b0;
      run_q       <= 1'b0;
      flag_q      <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == MODE_ADDR) begin
        src_q       <= src_sel_e'(wr_data_i[MODE_SRC_LSB +: 2]);
        idle_stop_q <= wr_data_i[MODE_IDLE_BIT];
        ie_q        <= wr_data_i[MODE_IE_BIT];
      end
      if (wr_en_i && addr_i == CTRL_ADDR)
        run_q <= wr_data_i[CTRL_RUN_BIT];
      // a wrap wins over a software write of the flag
      if (wrap)
        flag_q <= 1'b1;
      else if (wr_en_i && addr_i == CTRL_ADDR)
        flag_q <= wr_data_i[CTRL_FLAG_BIT];
      irq_o <= flag_q & ie_q;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NBYTES; b++)
      if (addr_i == ADDR_W'(b)) rd_next = count_o[b*BYTE_W +: BYTE_W];
    if (addr_i == MODE_ADDR) rd_next = BYTE_W'({ie_q, idle_stop_q, src_q});
    if (addr_i == CTRL_ADDR) rd_next = BYTE_W'({flag_q, run_q});
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_next;
  end
endmodule

// File: rtl/shared_timebase_checker.sv
module shared_timebase_checker #(
  parameter int CW     = 16,
  parameter int NBYTES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NBYTES-1:0] byte_we,
  input logic [CW-1:0]     count_o,
  input logic              count_en,
  input logic              run_q,
  input logic              idle_i,
  input logic              idle_stop_q,
  input logic              flag_q,
  input logic              ie_q,
  input logic              irq_o
);
  // R3 R4 R5 R6: without a byte write the count holds or steps by exactly one
  p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
    (byte_we == '0) |=> (count_o == $past(count_o) || count_o == $past(count_o) + CW'(1)));

  p_run_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!run_q && byte_we == '0) |=> $stable(count_o));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (idle_stop_q && idle_i && byte_we == '0) |=> $stable(count_o));

  p_wrap_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (count_en && byte_we == '0 && count_o == '1) |=> (flag_q && count_o == '0));

  p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == ($past(flag_q) && $past(ie_q))));
endmodule

bind shared_timebase shared_timebase_checker #(.CW(BYTE_W*NBYTES), .NBYTES(NBYTES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .byte_we     (byte_we),
  .count_o     (count_o),
  .count_en    (count_en),
  .run_q       (run_q),
  .idle_i      (idle_i),
  .idle_stop_q (idle_stop_q),
  .flag_q      (flag_q),
  .ie_q        (ie_q),
  .irq_o       (irq_o)
);

// File: tb/shared_timebase_test.sv
module shared_timebase_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        idle_i = 1'b0;
  logic        tmr_ovf_i = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [7:0]  wr_data_i = 8'd0;
  logic [7:0]  rd_data_o;
  logic [15:0] count_o;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shared_timebase uut (
    .clk(clk), .rst(rst), .idle_i(idle_i), .tmr_ovf_i(tmr_ovf_i),
    .ext_clk_i(ext_clk_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .count_o(count_o),
    .irq_o(irq_o)
  );

  typedef struct packed {
    logic [1:0]  src;
    logic [15:0] win;
    logic [7:0]  per;
    logic [15:0] exp;
  } vec_t;

  // prescaler entries carry their expected step count; event sources are counted while driven
  localparam vec_t VECS [7] = '{
    '{2'b00, 16'd120, 8'd0, 16'd10},
    '{2'b01, 16'd120, 8'd0, 16'd30},
    '{2'b00, 16'd36,  8'd0, 16'd3},
    '{2'b10, 16'd60,  8'd3, 16'd0},
    '{2'b10, 16'd30,  8'd1, 16'd0},
    '{2'b11, 16'd60,  8'd4, 16'd0},
    '{2'b11, 16'd40,  8'd1, 16'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [7:0]  r;
    logic [15:0] c0;
    int          ev;
    logic        nxt;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 count", count_o, 16'h0000);
    check("R1 irq", irq_o, 1'b0);
    rd(2'd2, r); check("R1 mode", r, 8'h00);
    rd(2'd3, r); check("R1 ctrl", r, 8'h00);

    // R2 register readback, run off
    wr(2'd0, 8'h34); wr(2'd1, 8'h12); wr(2'd2, 8'h0D);
    rd(2'd0, r); check("R2 low", r, 8'h34);
    rd(2'd1, r); check("R2 high", r, 8'h12);
    rd(2'd2, r); check("R2 mode", r, 8'h0D);
    check("R2 count_o", count_o, 16'h1234);

    // R3 R4 R5 R6: table walk with run on
    wr(2'd3, 8'h01);
    foreach (VECS[k]) begin
      wr(2'd2, {6'b0, VECS[k].src});
      c0 = count_o;
      ev = 0;
      for (int i = 0; i < VECS[k].win; i++) begin
        if (i < VECS[k].win - 10 && VECS[k].per != 0 && (i % VECS[k].per) == 0) begin
          if (VECS[k].src == 2'b10) begin
            tmr_ovf_i = 1'b1; ev++;
          end else if (VECS[k].src == 2'b11) begin
            nxt = ~ext_clk_i;
            if (nxt) ev++;
            ext_clk_i = nxt;
          end
        end else begin
          tmr_ovf_i = 1'b0;
          if (i >= VECS[k].win - 10) ext_clk_i = 1'b0;
        end
        @(negedge clk);
      end
      tmr_ovf_i = 1'b0; ext_clk_i = 1'b0;
      case (VECS[k].src)
        2'b00: check("R3 slow divide", count_o - c0, VECS[k].exp);
        2'b01: check("R4 fast divide", count_o - c0, VECS[k].exp);
        2'b10: check("R5 timer pulses", count_o - c0, ev);
        default: check("R6 pin edges", count_o - c0, ev);
      endcase
    end

    // R6 synchronizer latency: step visible on the third edge after the pin rises
    wr(2'd2, 8'h03);
    repeat (3) @(negedge clk);
    c0 = count_o;
    ext_clk_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 no early step", count_o - c0, 16'd0);
    @(negedge clk);
    check("R6 step on third edge", count_o - c0, 16'd1);
    ext_clk_i = 1'b0;
    repeat (3) @(negedge clk);

    // R7 run off freezes the count
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h01);
    c0 = count_o;
    repeat (40) @(negedge clk);
    check("R7 run off", count_o - c0, 16'd0);

    // R8 idle freeze
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h06);
    idle_i = 1'b1; tmr_ovf_i = 1'b1;
    c0 = count_o;
    repeat (20) @(negedge clk);
    check("R8 frozen while idle", count_o - c0, 16'd0);
    idle_i = 1'b0;
    c0 = count_o;
    repeat (10) @(negedge clk);
    check("R8 counts after idle", count_o - c0, 16'd10);
    tmr_ovf_i = 1'b0;
    wr(2'd2, 8'h02);
    idle_i = 1'b1; tmr_ovf_i = 1'b1;
    c0 = count_o;
    repeat (10) @(negedge clk);
    check("R8 idle ignored", count_o - c0, 16'd10);
    idle_i = 1'b0; tmr_ovf_i = 1'b0;

    // R11 write beats increment
    tmr_ovf_i = 1'b1;
    c0 = count_o;
    wr(2'd0, 8'h55);
    check("R11 low written", count_o[7:0], 8'h55);
    @(negedge clk);
    check("R11 resumes", count_o[7:0], 8'h56);
    c0 = count_o;
    wr(2'd1, 8'hA0);
    check("R11 high written", count_o, {8'hA0, c0[7:0]});
    tmr_ovf_i = 1'b0;

    // R9 R10 wrap with interrupt disabled
    wr(2'd3, 8'h00);
    wr(2'd0, 8'hFE); wr(2'd1, 8'hFF);
    wr(2'd3, 8'h01);
    tmr_ovf_i = 1'b1;
    repeat (2) @(negedge clk);
    tmr_ovf_i = 1'b0;
    check("R9 wrapped", count_o, 16'h0000);
    rd(2'd3, r); check("R9 flag set", r, 8'h03);
    check("R10 masked", irq_o, 1'b0);
    wr(2'd2, 8'h0A);
    check("R10 not yet", irq_o, 1'b0);
    @(negedge clk);
    check("R10 raised", irq_o, 1'b1);
    repeat (20) @(negedge clk);
    rd(2'd3, r); check("R9 sticky", r, 8'h03);
    wr(2'd3, 8'h01);
    @(negedge clk);
    check("R10 dropped", irq_o, 1'b0);
    rd(2'd3, r); check("R9 cleared", r, 8'h01);

    // R9 wrap and clearing write in the same cycle
    wr(2'd3, 8'h00);
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    wr(2'd3, 8'h01);
    tmr_ovf_i = 1'b1;
    wr(2'd3, 8'h01);
    tmr_ovf_i = 1'b0;
    check("R9 collision wrap", count_o, 16'h0000);
    rd(2'd3, r); check("R9 set wins", r, 8'h03);

    summary();
  end
endmodule